// File: doc/BRIEF.md
# Latched Parity Transceiver With Checking

This block is a two-sided 9-bit transceiver slice for a synchronous fabric. Each side, A and B, carries an 8-bit data word and one parity bit. Each side has its own capture stage that follows its inputs while its latch enable is high and keeps its last contents while the enable is low. Data captured on one side is forwarded to the other side. The forwarded parity bit is either regenerated from the captured data (generate mode) or copied from the captured incoming parity bit (feed-through mode). The mode is chosen by `ft_mode`.

Both sides check their captured data against their captured parity bit all the time, whatever the mode. Each side reports a mismatch on its own active-low error flag. The three-state pins are split into an input, an output and a registered drive indicator per side. Two active-low output enables pick which side is driven. If both are asserted at once, the B-to-A direction wins and side B stays undriven.

The capture stages are clocked registers whose update is gated by the latch enable. All outputs are registered. Captured data reaches the opposite side one clock edge after capture. Mode, parity type and enables take effect at the next edge.

Top module: `parity_xcvr`

## Requirements
- R1: `b_out` presents the A-side word captured at the previous clock edge. It updates regardless of the output enables.
- R2: `a_out` presents the B-side word captured at the previous clock edge. It updates regardless of the output enables.
- R3: With `ft_mode` low (generate), each forwarded parity bit equals the XOR of the forwarded word when `odd_sel` is 0 (even parity). It equals the inverse of that XOR when `odd_sel` is 1 (odd parity).
- R4: With `ft_mode` high (feed-through), each forwarded parity bit equals the parity bit captured on the source side, unchanged.
- R5: `a_err_n` (`b_err_n`) is 0 exactly when parity generated from that side's captured word, under the current `odd_sel`, differs from that side's captured parity bit. This holds in both modes and for any single-bit flip of data or parity.
- R6: While a side's latch enable is 0, changes on that side's data and parity inputs have no effect on the opposite side's outputs or on that side's error flag.
- R7: The two latch enables act independently. One side can capture new values while the other holds.
- R8: `a_drv` is 1 one edge after `a_oe_n` is sampled low. `b_drv` is 1 one edge after `b_oe_n` is sampled low while `a_oe_n` is high. The two are never 1 together.
- R9: A clock edge with `rst` high clears both captured words and both captured parity bits to 0. At that edge all data and parity outputs go to 0, both error flags go to 1, and both drive indicators go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | A-side data from the pins |
| a_par_in | input | 1 | A-side parity bit from the pins |
| a_le | input | 1 | A-side capture enable, high = follow inputs |
| b_in | input | 8 | B-side data from the pins |
| b_par_in | input | 1 | B-side parity bit from the pins |
| b_le | input | 1 | B-side capture enable, high = follow inputs |
| ft_mode | input | 1 | 0 = regenerate parity, 1 = feed parity through |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| a_oe_n | input | 1 | Drive side A with B-side data, active low, has priority |
| b_oe_n | input | 1 | Drive side B with A-side data, active low |
| a_out | output | 8 | Data toward side A |
| a_par_out | output | 1 | Parity toward side A |
| a_drv | output | 1 | Side A output is driven |
| b_out | output | 8 | Data toward side B |
| b_par_out | output | 1 | Parity toward side B |
| b_drv | output | 1 | Side B output is driven |
| a_err_n | output | 1 | A-side parity mismatch, active low |
| b_err_n | output | 1 | B-side parity mismatch, active low |

## Verification
The bench flips each of the nine bits of a correctly coded word on both sides, in both modes and for both parity types. A checker that ignored the parity bit, or that applied the wrong polarity for odd parity, would miss or invert those flags. The bench holds one side while it keeps changing that side's inputs. A capture stage that leaked input changes would then shift the forwarded word or the error flag. It asserts both output enables together, where a missing priority rule would drive both sides at once. It also sweeps every combination of mode, parity type and the two latch enables, so that cross-coupling between the sides shows up.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic {
    MODE_GEN  = 1'b0,
    MODE_FEED = 1'b1
  } fwd_mode_e;

  localparam int unsigned SIDES = 2;
  localparam int unsigned SIDE_A = 0;
  localparam int unsigned SIDE_B = 1;
endpackage

// File: rtl/ptx_port_latch.sv
module ptx_port_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          le,
  input  logic [DW-1:0] d_in,
  input  logic          p_in,
  output logic [DW-1:0] d_q,
  output logic          p_q
);
  // enable-gated capture: follows pins while le is high, holds otherwise
  always_ff @(posedge clk) begin
    if (rst) begin
      d_q <= '0;
      p_q <= 1'b0;
    end else if (le) begin
      d_q <= d_in;
      p_q <= p_in;
    end
  end
endmodule

// File: rtl/ptx_parity_chk.sv
module ptx_parity_chk #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] d,
  input  logic          p,
  input  logic          odd,
  output logic          gen,
  output logic          err_n
);
  // generated bit makes the total count of ones even (odd = 0) or odd (odd = 1)
  assign gen = (^d) ^ odd;

  always_ff @(posedge clk) begin
    if (rst) err_n <= 1'b1;
    else     err_n <= (gen == p);
  end
endmodule

// File: rtl/ptx_dir_drive.sv
module ptx_dir_drive
  import ptx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] src_d,
  input  logic          src_p,
  input  logic          src_gen,
  input  fwd_mode_e     mode,
  input  logic          en,
  output logic [DW-1:0] out_d,
  output logic          out_p,
  output logic          drv
);
  logic par_sel;

  always_comb begin
    unique case (mode)
      MODE_FEED: par_sel = src_p;
      default:   par_sel = src_gen;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_d <= '0;
      out_p <= 1'b0;
      drv   <= 1'b0;
    end else begin
      out_d <= src_d;
      out_p <= par_sel;
      drv   <= en;
    end
  end
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
  import ptx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_in,
  input  logic          a_par_in,
  input  logic          a_le,
  input  logic [DW-1:0] b_in,
  input  logic          b_par_in,
  input  logic          b_le,
  input  logic          ft_mode,
  input  logic          odd_sel,
  input  logic          a_oe_n,
  input  logic          b_oe_n,
  output logic [DW-1:0] a_out,
  output logic          a_par_out,
  output logic          a_drv,
  output logic [DW-1:0] b_out,
  output logic          b_par_out,
  output logic          b_drv,
  output logic          a_err_n,
  output logic          b_err_n
);
  logic [DW-1:0] pin_d  [SIDES];
  logic          pin_p  [SIDES];
  logic          cap_en [SIDES];
  logic [DW-1:0] lat_d  [SIDES];
  logic          lat_p  [SIDES];
  logic          gen_p  [SIDES];
  logic          err_q  [SIDES];
  logic          drv_en [SIDES];
  logic [DW-1:0] fwd_d  [SIDES];
  logic          fwd_p  [SIDES];
  logic          fwd_on [SIDES];
  fwd_mode_e     mode;

  assign mode = ft_mode ? MODE_FEED : MODE_GEN;

  assign pin_d[SIDE_A]  = a_in;
  assign pin_d[SIDE_B]  = b_in;
  assign pin_p[SIDE_A]  = a_par_in;
  assign pin_p[SIDE_B]  = b_par_in;
  assign cap_en[SIDE_A] = a_le;
  assign cap_en[SIDE_B] = b_le;

  // B-to-A direction wins when both enables are asserted
  assign drv_en[SIDE_A] = !a_oe_n;
  assign drv_en[SIDE_B] = !b_oe_n && a_oe_n;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int unsigned SRC = SIDES - 1 - s;

    ptx_port_latch #(.DW(DW)) u_lat (
      .clk  (clk),
      .rst  (rst),
      .le   (cap_en[s]),
      .d_in (pin_d[s]),
      .p_in (pin_p[s]),
      .d_q  (lat_d[s]),
      .p_q  (lat_p[s])
    );

    ptx_parity_chk #(.DW(DW)) u_chk (
      .clk   (clk),
      .rst   (rst),
      .d     (lat_d[s]),
      .p     (lat_p[s]),
      .odd   (odd_sel),
      .gen   (gen_p[s]),
      .err_n (err_q[s])
    );

    // output toward side s carries the data captured on the opposite side
    ptx_dir_drive #(.DW(DW)) u_drv (
      .clk     (clk),
      .rst     (rst),
      .src_d   (lat_d[SRC]),
      .src_p   (lat_p[SRC]),
      .src_gen (gen_p[SRC]),
      .mode    (mode),
      .en      (drv_en[s]),
      .out_d   (fwd_d[s]),
      .out_p   (fwd_p[s]),
      .drv     (fwd_on[s])
    );
  end

  assign a_out     = fwd_d[SIDE_A];
  assign a_par_out = fwd_p[SIDE_A];
  assign a_drv     = fwd_on[SIDE_A];
  assign b_out     = fwd_d[SIDE_B];
  assign b_par_out = fwd_p[SIDE_B];
  assign b_drv     = fwd_on[SIDE_B];
  assign a_err_n   = err_q[SIDE_A];
  assign b_err_n   = err_q[SIDE_B];
endmodule

// File: rtl/ptx_sva.sv
module ptx_sva #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          a_le,
  input logic          b_le,
  input logic          ft_mode,
  input logic          odd_sel,
  input logic          a_oe_n,
  input logic          b_oe_n,
  input logic [DW-1:0] a_out,
  input logic          a_par_out,
  input logic          a_drv,
  input logic [DW-1:0] b_out,
  input logic          b_par_out,
  input logic          b_drv,
  input logic          a_err_n,
  input logic          b_err_n
);
  // R9: state right after a reset edge
  a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (a_err_n && b_err_n && !a_drv && !b_drv &&
                    a_out == '0 && b_out == '0 && !a_par_out && !b_par_out));

  // R8: never drive both sides
  a_r8_single_driver: assert property (@(posedge clk) disable iff (rst)
    !(a_drv && b_drv));

  // R8: both enables low -> B-to-A wins
  a_r8_b_yields: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!a_oe_n) && $past(!b_oe_n)) |-> (a_drv && !b_drv));

  // R3: generate mode yields correct total parity on forwarded word
  a_r3_gen_parity_b: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!ft_mode)) |-> (((^b_out) ^ b_par_out) == $past(odd_sel)));

  a_r3_gen_parity_a: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!ft_mode)) |-> (((^a_out) ^ a_par_out) == $past(odd_sel)));

  // R4/R5: in feed-through the source flag agrees with the forwarded word and bit
  a_r5_feed_flag_a: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ft_mode)) |->
      (a_err_n == (((^b_out) ^ $past(odd_sel)) == b_par_out)));

  a_r5_feed_flag_b: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ft_mode)) |->
      (b_err_n == (((^a_out) ^ $past(odd_sel)) == a_par_out)));

  // R6: held capture keeps the forwarded word stable
  a_r6_hold_a: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rst, 2) && $past(!a_le, 2)) |-> $stable(b_out));

  a_r6_hold_b: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rst, 2) && $past(!b_le, 2)) |-> $stable(a_out));
endmodule

bind parity_xcvr ptx_sva #(.DW(DW)) u_sva (.*);

// File: tb/sim_parity_xcvr.sv
module sim_parity_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic          a_par_in = 1'b0, b_par_in = 1'b0;
  logic          a_le = 1'b0, b_le = 1'b0;
  logic          ft_mode = 1'b0, odd_sel = 1'b0;
  logic          a_oe_n = 1'b1, b_oe_n = 1'b1;
  logic [DW-1:0] a_out, b_out;
  logic          a_par_out, b_par_out, a_drv, b_drv, a_err_n, b_err_n;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [DW-1:0] m_la_d = '0, m_lb_d = '0;
  logic          m_la_p = 1'b0, m_lb_p = 1'b0;
  logic [DW-1:0] e_a_out = '0, e_b_out = '0;
  logic          e_a_par = 1'b0, e_b_par = 1'b0;
  logic          e_a_drv = 1'b0, e_b_drv = 1'b0;
  logic          e_a_err = 1'b1, e_b_err = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_xcvr #(.DW(DW)) u0 (
    .clk, .rst, .a_in, .a_par_in, .a_le, .b_in, .b_par_in, .b_le,
    .ft_mode, .odd_sel, .a_oe_n, .b_oe_n,
    .a_out, .a_par_out, .a_drv, .b_out, .b_par_out, .b_drv,
    .a_err_n, .b_err_n
  );

  function automatic logic par_gen(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock edge: update model from values present at the edge, then compare
  task automatic step();
    @(posedge clk);
    if (rst) begin
      e_a_out = '0; e_b_out = '0; e_a_par = 0; e_b_par = 0;
      e_a_drv = 0; e_b_drv = 0; e_a_err = 1; e_b_err = 1;
      m_la_d = '0; m_lb_d = '0; m_la_p = 0; m_lb_p = 0;
    end else begin
      e_b_out = m_la_d;
      e_a_out = m_lb_d;
      e_b_par = ft_mode ? m_la_p : par_gen(m_la_d, odd_sel);
      e_a_par = ft_mode ? m_lb_p : par_gen(m_lb_d, odd_sel);
      e_a_drv = !a_oe_n;
      e_b_drv = !b_oe_n && a_oe_n;
      e_a_err = (par_gen(m_la_d, odd_sel) == m_la_p);
      e_b_err = (par_gen(m_lb_d, odd_sel) == m_lb_p);
      if (a_le) begin m_la_d = a_in; m_la_p = a_par_in; end
      if (b_le) begin m_lb_d = b_in; m_lb_p = b_par_in; end
    end
    @(negedge clk);
    chk(b_out == e_b_out, "R1 b_out", b_out, e_b_out);
    chk(a_out == e_a_out, "R2 a_out", a_out, e_a_out);
    chk(b_par_out == e_b_par, ft_mode ? "R4 b_par_out" : "R3 b_par_out", b_par_out, e_b_par);
    chk(a_par_out == e_a_par, ft_mode ? "R4 a_par_out" : "R3 a_par_out", a_par_out, e_a_par);
    chk(a_err_n == e_a_err, "R5 a_err_n", a_err_n, e_a_err);
    chk(b_err_n == e_b_err, "R5 b_err_n", b_err_n, e_b_err);
    chk(a_drv == e_a_drv, "R8 a_drv", a_drv, e_a_drv);
    chk(b_drv == e_b_drv, "R8 b_drv", b_drv, e_b_drv);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] base;
    logic [DW-1:0] held;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    repeat (3) step();
    // R9: reset values
    chk(a_err_n && b_err_n, "R9 err flags high", {a_err_n, b_err_n}, 3);
    chk(!a_drv && !b_drv, "R9 drivers off", {a_drv, b_drv}, 0);
    chk(a_out == 0 && b_out == 0, "R9 outputs zero", {a_out, b_out}, 0);
    rst = 1'b0;
    step();

    // sweep mode, parity type and latch enables
    for (int m = 0; m < 16; m++) begin
      ft_mode = m[0]; odd_sel = m[1]; a_le = m[2]; b_le = m[3];
      for (int k = 0; k < 6; k++) begin
        a_in = DW'($urandom); b_in = DW'($urandom);
        a_par_in = 1'($urandom); b_par_in = 1'($urandom);
        a_oe_n = 1'($urandom); b_oe_n = 1'($urandom);
        step();
      end
    end

    // R7: A captures while B holds
    b_le = 1'b1; b_in = 8'h3c; b_par_in = 1'b0; a_le = 1'b1;
    step(); step();
    b_le = 1'b0; b_in = 8'hff;
    a_in = 8'h81; step(); a_in = 8'h42; step(); step();
    chk(b_out == 8'h42, "R7 A side captured", b_out, 8'h42);
    chk(a_out == 8'h3c, "R7 B side held", a_out, 8'h3c);

    // single-bit error injection on every data and parity bit
    a_le = 1'b1; b_le = 1'b1;
    for (int md = 0; md < 4; md++) begin
      ft_mode = md[0]; odd_sel = md[1];
      for (int bt = 0; bt <= DW; bt++) begin
        base = DW'($urandom);
        a_in = base; b_in = ~base;
        a_par_in = par_gen(base, odd_sel);
        b_par_in = par_gen(~base, odd_sel);
        if (bt < DW) begin a_in[bt] = ~a_in[bt]; b_in[bt] = ~b_in[bt]; end
        else begin a_par_in = ~a_par_in; b_par_in = ~b_par_in; end
        step(); step();
        chk(!a_err_n, "R5 A single-bit flip", a_err_n, 0);
        chk(!b_err_n, "R5 B single-bit flip", b_err_n, 0);
        a_in = base; a_par_in = par_gen(base, odd_sel);
        step(); step();
        chk(a_err_n, "R5 A clean word", a_err_n, 1);
      end
    end

    // R6: held side ignores input changes
    ft_mode = 1'b1; odd_sel = 1'b0;
    a_in = 8'h5a; a_par_in = 1'b1; a_le = 1'b1; b_le = 1'b1;
    step(); step();
    held = b_out;
    a_le = 1'b0;
    for (int k = 0; k < 8; k++) begin
      a_in = DW'($urandom); a_par_in = 1'($urandom);
      step();
      chk(b_out == held, "R6 held word", b_out, held);
      chk(b_par_out == 1'b1, "R6 held parity", b_par_out, 1);
      chk(!a_err_n, "R6 held flag", a_err_n, 0);
    end

    // R8: both enables low, B-to-A wins
    a_oe_n = 1'b0; b_oe_n = 1'b0; step();
    chk(a_drv && !b_drv, "R8 priority", {a_drv, b_drv}, 2);
    a_oe_n = 1'b1; step();
    chk(!a_drv && b_drv, "R8 B drives alone", {a_drv, b_drv}, 1);

    // constrained random
    for (int k = 0; k < 1500; k++) begin
      a_in = DW'($urandom); b_in = DW'($urandom);
      a_par_in = 1'($urandom); b_par_in = 1'($urandom);
      a_le = ($urandom % 4) != 0; b_le = ($urandom % 3) != 0;
      ft_mode = 1'($urandom); odd_sel = 1'($urandom);
      a_oe_n = 1'($urandom); b_oe_n = 1'($urandom);
      step();
    end

    // R9: reset from a busy state
    rst = 1'b1; step();
    chk(a_out == 0 && b_out == 0 && a_err_n && b_err_n, "R9 reset mid-run",
        {a_out, b_out}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule